// File: doc/BRIEF.md
# I2C Real-Time-Clock Transaction Monitor

This block watches a stream of I2C bus events that an upstream decoder has already produced, one event per clock with its data byte, and follows the register traffic aimed at a real-time-clock device. It never drives the bus. It recognises the address of the clock device and learns the register pointer from the first written byte. It then stores each later written or read byte into a shadow copy of the register that the pointer selects, and the pointer steps forward after each byte. When the transaction ends with a stop, the monitor emits one calendar record holding seconds, minutes, hours, day, month and year. The BCD fields are converted to binary, and the record is marked as a read or a write.

A repeated start after the pointer byte moves the monitor onto the read path, which is the usual way software reads the clock back. Bytes that fall on registers holding no calendar data are counted in the record but leave the time fields alone. The status and control flags from the clock's control register, the weekday, the low-voltage flag and the century flag are brought out as live outputs.

Top module: `rtc_txn_monitor`

## Requirements
- R1: After reset, rec_valid is 0, rec_field_valid is 0, all record fields are 0, and every flag output (volt_low, century, tmr_repeat, alarm_flag, timer_flag, alarm_ie, timer_ie, weekday) is 0.
- R2: Event codes on ev_kind are 0 start, 1 repeated start, 2 address write, 3 address read, 4 data write, 5 data read, 6 stop, 7 NACK. The write sequence is start, then address write with byte 0xA2, then a data write whose low 4 bits load the register pointer. Each further data-write byte is stored at the pointer, and the pointer then increments, wrapping from 0x0F to 0x00.
- R3: A repeated start after the pointer is loaded selects the read path. An address read with byte 0xA3 follows, and each data-read byte is then stored at the pointer, which then increments.
- R4: A stop in the write-data or read-data phase, including after a NACK, raises rec_valid for exactly one cycle, on the cycle after the stop event. rec_is_read is 1 for the read path and 0 for the write path. A stop in any other state returns the monitor to idle and emits nothing.
- R5: Field layout: register 2 holds seconds in bits 6:0 and volt_low in bit 7. Register 3 holds minutes in bits 6:0, register 4 holds hours in bits 5:0, register 5 holds the day in bits 5:0 and register 6 holds the weekday in bits 2:0. Register 7 holds the month in bits 4:0 and century in bit 7, and register 8 holds the year in bits 7:0. Reserved upper bits are ignored. Record fields are binary, tens digit times 10 plus units digit.
- R6: Register 1 drives tmr_repeat (bit 4), alarm_flag (bit 3), timer_flag (bit 2), alarm_ie (bit 1) and timer_ie (bit 0). These outputs, weekday, volt_low and century change on the cycle after the capturing byte.
- R7: An address write other than 0xA2, or an address read other than 0xA3, returns the monitor to idle. Data that follows is not stored and no record is emitted.
- R8: rec_field_valid bits are [0] seconds, [1] minutes, [2] hours, [3] day, [4] month and [5] year. Each bit is set once its field has been captured and stays set. A field not captured in a transaction keeps its previous value.
- R9: A NACK in a data phase ends capture for the rest of the transaction. Later data bytes are ignored, and the stop still emits a record.
- R10: A start, or a repeated start outside the write-data phase, in any non-idle state restarts the sequence at address matching and clears the byte count.
- R11: rec_bytes counts the data bytes stored after the pointer in the transaction. Bytes landing on registers 0x00 and 0x09 to 0x0F are counted but change no time field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_valid | input | 1 | An event is present this cycle |
| ev_kind | input | 3 | Event code |
| ev_data | input | 8 | Address or data byte of the event |
| rec_valid | output | 1 | One-cycle record strobe |
| rec_is_read | output | 1 | Record came from the read path |
| rec_seconds | output | 8 | Seconds, binary |
| rec_minutes | output | 8 | Minutes, binary |
| rec_hours | output | 8 | Hours, binary |
| rec_day | output | 8 | Day of month, binary |
| rec_month | output | 8 | Month, binary |
| rec_year | output | 8 | Year, binary |
| rec_field_valid | output | 6 | Per-field captured bits |
| rec_bytes | output | CNT_W | Data bytes stored in the transaction |
| weekday | output | 3 | Weekday field |
| volt_low | output | 1 | Low-voltage flag |
| century | output | 1 | Century flag |
| tmr_repeat | output | 1 | Timer repeat mode flag |
| alarm_flag | output | 1 | Alarm event flag |
| timer_flag | output | 1 | Timer event flag |
| alarm_ie | output | 1 | Alarm interrupt enable |
| timer_ie | output | 1 | Timer interrupt enable |

## Verification
The bench drives a burst that starts at the pointer and crosses 0x0F. A design that failed to wrap would miss the seconds byte after the wrap, and one that decoded the non-calendar registers would corrupt the time fields. It sends a foreign write address, a foreign read address and a restart in the middle of a transaction. A monitor that leaked through any of these would store stray bytes or emit a spurious record, and the next genuine record exposes either fault. A NACK is followed by more data on both the read and the write path, so a monitor that kept capturing would change minutes or day. Partial bursts check that uncaptured fields hold their values while their valid bits stay clear.

// File: rtl/rtc_mon_pkg.sv
package rtc_mon_pkg;

    typedef enum logic [2:0] {
        EV_START   = 3'd0,
        EV_RSTART  = 3'd1,
        EV_ADDR_WR = 3'd2,
        EV_ADDR_RD = 3'd3,
        EV_DATA_WR = 3'd4,
        EV_DATA_RD = 3'd5,
        EV_STOP    = 3'd6,
        EV_NACK    = 3'd7
    } ev_kind_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT_AW,
        ST_WAIT_PTR,
        ST_WR_DATA,
        ST_WAIT_AR,
        ST_RD_DATA,
        ST_HALT
    } mon_state_e;

    localparam logic [7:0] DEV_WR_ADDR = 8'hA2;
    localparam logic [7:0] DEV_RD_ADDR = 8'hA3;

    localparam int REG_CTRL = 1;
    localparam int REG_SEC  = 2;
    localparam int REG_MIN  = 3;
    localparam int REG_HOUR = 4;
    localparam int REG_DAY  = 5;
    localparam int REG_WDAY = 6;
    localparam int REG_MON  = 7;
    localparam int REG_YEAR = 8;

    localparam int NUM_FIELDS = 6;

    typedef struct packed {
        logic [7:0] year;
        logic [7:0] month;
        logic [7:0] day;
        logic [7:0] hours;
        logic [7:0] minutes;
        logic [7:0] seconds;
    } cal_time_t;

    function automatic logic [7:0] bcd_to_bin(input logic [7:0] b);
        return ({4'd0, b[7:4]} * 8'd10) + {4'd0, b[3:0]};
    endfunction

endpackage

// File: rtl/rtc_seq_fsm.sv
module rtc_seq_fsm
    import rtc_mon_pkg::*;
#(
    parameter int PTR_W = 4,
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ev_valid,
    input  ev_kind_e         ev_kind,
    input  logic [7:0]       ev_data,
    output logic             cap_en,
    output logic [PTR_W-1:0] cap_ptr,
    output logic             emit,
    output logic             rec_fire,
    output logic             rec_rd,
    output logic [CNT_W-1:0] rec_cnt
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    mon_state_e       state;
    logic [PTR_W-1:0] ptr;
    logic [CNT_W-1:0] cnt;
    logic             is_rd;
    logic             in_data;

    assign in_data = (state == ST_WR_DATA) || (state == ST_RD_DATA) || (state == ST_HALT);
    assign cap_en  = ev_valid &&
                     (((state == ST_WR_DATA) && (ev_kind == EV_DATA_WR)) ||
                      ((state == ST_RD_DATA) && (ev_kind == EV_DATA_RD)));
    assign cap_ptr = ptr;
    assign emit    = ev_valid && (ev_kind == EV_STOP) && in_data;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            ptr      <= '0;
            cnt      <= '0;
            is_rd    <= 1'b0;
            rec_fire <= 1'b0;
            rec_rd   <= 1'b0;
            rec_cnt  <= '0;
        end else begin
            rec_fire <= 1'b0;
            if (cap_en) begin
                ptr <= ptr + 1'b1;
                if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
            end
            if (ev_valid) begin
                case (ev_kind)
                    EV_START: begin
                        state <= ST_WAIT_AW;
                        cnt   <= '0;
                        is_rd <= 1'b0;
                    end
                    EV_RSTART: begin
                        if (state == ST_WR_DATA) begin
                            state <= ST_WAIT_AR;
                        end else if (state != ST_IDLE) begin
                            state <= ST_WAIT_AW;
                            cnt   <= '0;
                            is_rd <= 1'b0;
                        end
                    end
                    EV_ADDR_WR: begin
                        if (state == ST_WAIT_AW)
                            state <= (ev_data == DEV_WR_ADDR) ? ST_WAIT_PTR : ST_IDLE;
                        else if (state == ST_WAIT_AR)
                            state <= ST_IDLE;
                    end
                    EV_ADDR_RD: begin
                        if (state == ST_WAIT_AR) begin
                            if (ev_data == DEV_RD_ADDR) begin
                                state <= ST_RD_DATA;
                                is_rd <= 1'b1;
                            end else begin
                                state <= ST_IDLE;
                            end
                        end else if (state == ST_WAIT_AW) begin
                            state <= ST_IDLE;
                        end
                    end
                    EV_DATA_WR: begin
                        if (state == ST_WAIT_PTR) begin
                            ptr   <= ev_data[PTR_W-1:0];
                            state <= ST_WR_DATA;
                        end
                    end
                    EV_NACK: begin
                        if ((state == ST_WR_DATA) || (state == ST_RD_DATA))
                            state <= ST_HALT;
                    end
                    EV_STOP: begin
                        if (in_data) begin
                            rec_fire <= 1'b1;
                            rec_rd   <= is_rd;
                            rec_cnt  <= cnt;
                        end
                        state <= ST_IDLE;
                    end
                    default: ;
                endcase
            end
        end
    end

    // R2: pointer steps by one after every stored byte
    a_r2_ptr_step: assert property (@(posedge clk) disable iff (rst)
        cap_en |=> (ptr == PTR_W'($past(ptr) + 1'b1)));

    // R7: foreign write address drops back to idle
    a_r7_foreign_addr: assert property (@(posedge clk) disable iff (rst)
        (ev_valid && (ev_kind == EV_ADDR_WR) && (state == ST_WAIT_AW) &&
         (ev_data != DEV_WR_ADDR)) |=> (state == ST_IDLE));

endmodule

// File: rtl/rtc_time_regs.sv
module rtc_time_regs
    import rtc_mon_pkg::*;
#(
    parameter int PTR_W = 4
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  cap_en,
    input  logic [PTR_W-1:0]      cap_ptr,
    input  logic [7:0]            cap_byte,
    input  logic                  emit,
    output cal_time_t             snap_time,
    output logic [NUM_FIELDS-1:0] snap_valid,
    output logic [4:0]            ctrl_flags,
    output logic [2:0]            wday,
    output logic                  vl_flag,
    output logic                  cent_flag
);

    logic [6:0] sec_raw, min_raw;
    logic [5:0] hour_raw, day_raw;
    logic [4:0] mon_raw;
    logic [7:0] year_raw;
    logic [NUM_FIELDS-1:0] fv;

    always_ff @(posedge clk) begin
        if (rst) begin
            sec_raw    <= '0;
            min_raw    <= '0;
            hour_raw   <= '0;
            day_raw    <= '0;
            mon_raw    <= '0;
            year_raw   <= '0;
            fv         <= '0;
            ctrl_flags <= '0;
            wday       <= '0;
            vl_flag    <= 1'b0;
            cent_flag  <= 1'b0;
            snap_time  <= '0;
            snap_valid <= '0;
        end else begin
            if (cap_en) begin
                case (cap_ptr)
                    PTR_W'(REG_CTRL): ctrl_flags <= cap_byte[4:0];
                    PTR_W'(REG_SEC): begin
                        sec_raw <= cap_byte[6:0];
                        vl_flag <= cap_byte[7];
                        fv[0]   <= 1'b1;
                    end
                    PTR_W'(REG_MIN): begin
                        min_raw <= cap_byte[6:0];
                        fv[1]   <= 1'b1;
                    end
                    PTR_W'(REG_HOUR): begin
                        hour_raw <= cap_byte[5:0];
                        fv[2]    <= 1'b1;
                    end
                    PTR_W'(REG_DAY): begin
                        day_raw <= cap_byte[5:0];
                        fv[3]   <= 1'b1;
                    end
                    PTR_W'(REG_WDAY): wday <= cap_byte[2:0];
                    PTR_W'(REG_MON): begin
                        mon_raw   <= cap_byte[4:0];
                        cent_flag <= cap_byte[7];
                        fv[4]     <= 1'b1;
                    end
                    PTR_W'(REG_YEAR): begin
                        year_raw <= cap_byte;
                        fv[5]    <= 1'b1;
                    end
                    default: ;
                endcase
            end
            if (emit) begin
                snap_time.seconds <= bcd_to_bin({1'b0, sec_raw});
                snap_time.minutes <= bcd_to_bin({1'b0, min_raw});
                snap_time.hours   <= bcd_to_bin({2'b0, hour_raw});
                snap_time.day     <= bcd_to_bin({2'b0, day_raw});
                snap_time.month   <= bcd_to_bin({3'b0, mon_raw});
                snap_time.year    <= bcd_to_bin(year_raw);
                snap_valid        <= fv;
            end
        end
    end

    // R8: a captured-field bit never clears once set
    a_r8_valid_sticky: assert property (@(posedge clk) disable iff (rst)
        (($past(fv) & ~fv) == '0));

endmodule

// File: rtl/rtc_txn_monitor.sv
module rtc_txn_monitor
    import rtc_mon_pkg::*;
#(
    parameter int PTR_W = 4,
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ev_valid,
    input  logic [2:0]       ev_kind,
    input  logic [7:0]       ev_data,
    output logic             rec_valid,
    output logic             rec_is_read,
    output logic [7:0]       rec_seconds,
    output logic [7:0]       rec_minutes,
    output logic [7:0]       rec_hours,
    output logic [7:0]       rec_day,
    output logic [7:0]       rec_month,
    output logic [7:0]       rec_year,
    output logic [5:0]       rec_field_valid,
    output logic [CNT_W-1:0] rec_bytes,
    output logic [2:0]       weekday,
    output logic             volt_low,
    output logic             century,
    output logic             tmr_repeat,
    output logic             alarm_flag,
    output logic             timer_flag,
    output logic             alarm_ie,
    output logic             timer_ie
);

    ev_kind_e              kind;
    logic                  cap_en;
    logic [PTR_W-1:0]      cap_ptr;
    logic                  emit;
    cal_time_t             snap_time;
    logic [NUM_FIELDS-1:0] snap_valid;
    logic [4:0]            ctrl_flags;

    assign kind = ev_kind_e'(ev_kind);

    rtc_seq_fsm #(.PTR_W(PTR_W), .CNT_W(CNT_W)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .ev_valid (ev_valid),
        .ev_kind  (kind),
        .ev_data  (ev_data),
        .cap_en   (cap_en),
        .cap_ptr  (cap_ptr),
        .emit     (emit),
        .rec_fire (rec_valid),
        .rec_rd   (rec_is_read),
        .rec_cnt  (rec_bytes)
    );

    rtc_time_regs #(.PTR_W(PTR_W)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .cap_en     (cap_en),
        .cap_ptr    (cap_ptr),
        .cap_byte   (ev_data),
        .emit       (emit),
        .snap_time  (snap_time),
        .snap_valid (snap_valid),
        .ctrl_flags (ctrl_flags),
        .wday       (weekday),
        .vl_flag    (volt_low),
        .cent_flag  (century)
    );

    assign rec_seconds     = snap_time.seconds;
    assign rec_minutes     = snap_time.minutes;
    assign rec_hours       = snap_time.hours;
    assign rec_day         = snap_time.day;
    assign rec_month       = snap_time.month;
    assign rec_year        = snap_time.year;
    assign rec_field_valid = snap_valid;
    assign tmr_repeat      = ctrl_flags[4];
    assign alarm_flag      = ctrl_flags[3];
    assign timer_flag      = ctrl_flags[2];
    assign alarm_ie        = ctrl_flags[1];
    assign timer_ie        = ctrl_flags[0];

    // R4: a record strobe only ever follows a stop event
    a_r4_rec_after_stop: assert property (@(posedge clk) disable iff (rst)
        rec_valid |-> $past(ev_valid && (ev_kind == 3'd6)));

endmodule

// File: tb/tb_rtc_txn_monitor.sv
`timescale 1ns/1ps
module tb_rtc_txn_monitor;
    import rtc_mon_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ev_valid = 1'b0;
    logic [2:0] ev_kind = 3'd0;
    logic [7:0] ev_data = 8'd0;
    logic rec_valid, rec_is_read;
    logic [7:0] rec_seconds, rec_minutes, rec_hours, rec_day, rec_month, rec_year;
    logic [5:0] rec_field_valid;
    logic [7:0] rec_bytes;
    logic [2:0] weekday;
    logic volt_low, century, tmr_repeat, alarm_flag, timer_flag, alarm_ie, timer_ie;

    always #2.5 clk = ~clk;

    rtc_txn_monitor dut (
        .clk(clk), .rst(rst), .ev_valid(ev_valid), .ev_kind(ev_kind), .ev_data(ev_data),
        .rec_valid(rec_valid), .rec_is_read(rec_is_read),
        .rec_seconds(rec_seconds), .rec_minutes(rec_minutes), .rec_hours(rec_hours),
        .rec_day(rec_day), .rec_month(rec_month), .rec_year(rec_year),
        .rec_field_valid(rec_field_valid), .rec_bytes(rec_bytes), .weekday(weekday),
        .volt_low(volt_low), .century(century), .tmr_repeat(tmr_repeat),
        .alarm_flag(alarm_flag), .timer_flag(timer_flag), .alarm_ie(alarm_ie),
        .timer_ie(timer_ie)
    );

    typedef struct packed {
        logic       rd;
        logic [7:0] sec, min, hr, day, mon, yr;
        logic [5:0] fv;
        logic [7:0] bytes;
    } rec_t;

    rec_t  exp_q[$];
    string tag_q[$];
    int    n_tests = 0;
    int    n_fail  = 0;
    bit    done    = 0;

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic send(ev_kind_e k, logic [7:0] d);
        ev_valid = 1'b1;
        ev_kind  = k;
        ev_data  = d;
        @(negedge clk);
        ev_valid = 1'b0;
    endtask

    task automatic expect_rec(string tag, bit rd, logic [7:0] s, logic [7:0] mi,
                              logic [7:0] h, logic [7:0] dy, logic [7:0] mo,
                              logic [7:0] y, logic [5:0] fv, logic [7:0] nb);
        exp_q.push_back('{rd, s, mi, h, dy, mo, y, fv, nb});
        tag_q.push_back(tag);
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (!rst && rec_valid) begin
            rec_t  act;
            rec_t  exp;
            string tg;
            act = '{rec_is_read, rec_seconds, rec_minutes, rec_hours, rec_day,
                    rec_month, rec_year, rec_field_valid, rec_bytes};
            n_tests++;
            if (exp_q.size() == 0) begin
                n_fail++;
                $display("FAIL R4 unexpected record actual=%0h expected=none", act);
            end else begin
                exp = exp_q.pop_front();
                tg  = tag_q.pop_front();
                if (act !== exp) begin
                    n_fail++;
                    $display("FAIL %s record actual=%0h expected=%0h", tg, act, exp);
                end
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 5);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk("R1 rec_valid", rec_valid, 0);
        chk("R1 field_valid", rec_field_valid, 0);
        chk("R1 fields", {rec_seconds, rec_minutes, rec_year}, 0);
        chk("R1 flags", {weekday, volt_low, century, tmr_repeat, alarm_flag,
                         timer_flag, alarm_ie, timer_ie}, 0);

        // R8 partial write: only minutes captured
        expect_rec("R8", 0, 0, 17, 0, 0, 0, 0, 6'h02, 1);
        send(EV_START, 0); send(EV_ADDR_WR, 8'hA2); send(EV_DATA_WR, 8'h03);
        send(EV_DATA_WR, 8'h17); send(EV_STOP, 0);

        // R2 R5 R6 full write burst from register 1
        expect_rec("R5", 0, 45, 59, 23, 31, 12, 99, 6'h3F, 8);
        send(EV_START, 0); send(EV_ADDR_WR, 8'hA2); send(EV_DATA_WR, 8'h01);
        send(EV_DATA_WR, 8'h15);
        chk("R6 ctrl flags", {tmr_repeat, alarm_flag, timer_flag, alarm_ie, timer_ie}, 5'b10101);
        send(EV_DATA_WR, 8'hC5); send(EV_DATA_WR, 8'hD9); send(EV_DATA_WR, 8'hE3);
        send(EV_DATA_WR, 8'h31); send(EV_DATA_WR, 8'hFD); send(EV_DATA_WR, 8'h92);
        send(EV_DATA_WR, 8'h99); send(EV_STOP, 0);
        chk("R5 volt_low", volt_low, 1);
        chk("R5 century", century, 1);
        chk("R5 weekday", weekday, 5);

        // R3 R11 read path via repeated start, crosses into register 9
        expect_rec("R3", 1, 45, 59, 23, 31, 1, 0, 6'h3F, 3);
        send(EV_START, 0); send(EV_ADDR_WR, 8'hA2); send(EV_DATA_WR, 8'h07);
        send(EV_RSTART, 0); send(EV_ADDR_RD, 8'hA3);
        send(EV_DATA_RD, 8'h01); send(EV_DATA_RD, 8'h00); send(EV_DATA_RD, 8'h00);
        send(EV_STOP, 0);
        chk("R3 century", century, 0);

        // R2 R11 wrap from 0x0F to 0x00 and on to seconds
        expect_rec("R2", 0, 10, 59, 23, 31, 1, 0, 6'h3F, 5);
        send(EV_START, 0); send(EV_ADDR_WR, 8'hA2); send(EV_DATA_WR, 8'h0E);
        send(EV_DATA_WR, 8'hAA); send(EV_DATA_WR, 8'hBB); send(EV_DATA_WR, 8'h30);
        send(EV_DATA_WR, 8'h00);
        chk("R6 ctrl cleared", {tmr_repeat, alarm_flag, timer_flag, alarm_ie, timer_ie}, 0);
        send(EV_DATA_WR, 8'h10); send(EV_STOP, 0);
        chk("R11 volt_low", volt_low, 0);

        // R7 foreign write address and foreign read address
        send(EV_START, 0); send(EV_ADDR_WR, 8'hD0); send(EV_DATA_WR, 8'h02);
        send(EV_DATA_WR, 8'h33); send(EV_STOP, 0);
        send(EV_START, 0); send(EV_ADDR_WR, 8'hA2); send(EV_DATA_WR, 8'h02);
        send(EV_RSTART, 0); send(EV_ADDR_RD, 8'hA5); send(EV_DATA_RD, 8'h44);
        send(EV_STOP, 0);
        expect_rec("R7", 0, 10, 59, 23, 31, 1, 0, 6'h3F, 0);
        send(EV_START, 0); send(EV_ADDR_WR, 8'hA2); send(EV_DATA_WR, 8'h03);
        send(EV_STOP, 0);

        // R9 NACK on write path
        expect_rec("R9", 0, 21, 59, 23, 31, 1, 0, 6'h3F, 1);
        send(EV_START, 0); send(EV_ADDR_WR, 8'hA2); send(EV_DATA_WR, 8'h02);
        send(EV_DATA_WR, 8'h21); send(EV_NACK, 0); send(EV_DATA_WR, 8'h11);
        send(EV_STOP, 0);

        // R9 NACK on read path
        expect_rec("R9", 1, 21, 59, 8, 31, 1, 0, 6'h3F, 1);
        send(EV_START, 0); send(EV_ADDR_WR, 8'hA2); send(EV_DATA_WR, 8'h04);
        send(EV_RSTART, 0); send(EV_ADDR_RD, 8'hA3); send(EV_DATA_RD, 8'h08);
        send(EV_NACK, 0); send(EV_DATA_RD, 8'h09); send(EV_STOP, 0);

        // R10 start mid-transaction restarts address matching
        expect_rec("R10", 0, 5, 44, 8, 31, 1, 0, 6'h3F, 1);
        send(EV_START, 0); send(EV_ADDR_WR, 8'hA2); send(EV_DATA_WR, 8'h02);
        send(EV_DATA_WR, 8'h05); send(EV_START, 0); send(EV_ADDR_WR, 8'hA2);
        send(EV_DATA_WR, 8'h03); send(EV_DATA_WR, 8'h44); send(EV_STOP, 0);
        send(EV_START, 0); send(EV_ADDR_WR, 8'hA2); send(EV_DATA_WR, 8'h02);
        send(EV_START, 0); send(EV_DATA_WR, 8'h55); send(EV_DATA_WR, 8'h56);
        send(EV_STOP, 0);
        expect_rec("R10", 0, 5, 44, 8, 31, 1, 0, 6'h3F, 0);
        send(EV_START, 0); send(EV_ADDR_WR, 8'hA2); send(EV_DATA_WR, 8'h09);
        send(EV_STOP, 0);

        // R4 stop before pointer, and stop after bare start: no record
        send(EV_START, 0); send(EV_ADDR_WR, 8'hA2); send(EV_STOP, 0);
        send(EV_START, 0); send(EV_STOP, 0);
        repeat (4) @(negedge clk);
        chk("R4 all records seen", exp_q.size(), 0);
        finish_run();
    end

endmodule